// File: doc/BRIEF.md
# Truncated Fixed-Width Adder Tree

This block adds a group of unsigned operands and returns a result exactly as wide as one operand: the upper bits of the total. No full-width sum is ever built. The lowest `P = log2(N_OPS)` bit positions of every operand are dropped before any addition. A constant bias of `N_OPS/2` units of the lowest kept position stands in for the dropped bits. The bias is injected as the carry-in of each first-level adder, since the first level has exactly `N_OPS/2` nodes.

The tree is balanced and has `P` levels. Each level's nodes are one bit wider than the level below. Every two-input node is a carry-select adder. The low half of a node is added once. The high half is added twice, once for carry-in 0 and once for carry-in 1. The low half's carry then picks between the two high results. A build-time switch chooses between a purely combinational path and a registered output. The registered output appears one cycle after the input, qualified by a valid flag.

Top module: `fxat_trunc_sum`

## Requirements
- R1: For every accepted input, the result equals the sum over all operands of `(op >> P)`, plus `N_OPS/2`, truncated to `OP_W` bits. With the defaults (`N_OPS=8`, `OP_W=8`), `P=3` and the bias is 4.
- R2: Bits `[P-1:0]` of every operand have no effect on the result.
- R3: The result never overflows `OP_W` bits. All-ones operands give `2^OP_W - N_OPS/2`, which is 252 with the defaults.
- R4: All-zero operands give exactly the bias, `N_OPS/2` (4 with the defaults).
- R5: With the registered output, `out_valid_o` is high in the cycle after each cycle with `in_valid_i` high, and only then. `out_sum_o` in that cycle belongs to that input.
- R6: With the registered output, `out_sum_o` holds its value across any cycle in which `in_valid_i` is low, whatever the operands do.
- R7: While `rst_ni` is low, `out_valid_o` and `out_sum_o` are 0.
- R8: Each carry-select node produces the exact sum of its two inputs and its carry-in, including when a carry crosses the boundary between its halves.
- R9: The result differs from the exact full sum shifted right by `P` by at most `N_OPS/2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_ops_i | input | N_OPS*OP_W | Operands, operand k at bits [k*OP_W +: OP_W] |
| in_valid_i | input | 1 | Operands valid this cycle |
| out_sum_o | output | OP_W | Truncated, biased fixed-width sum |
| out_valid_o | output | 1 | Result valid |

## Verification
Two events can land in the same cycle. A new result is captured while the previous one is being presented, and a hold cycle must keep the captured value while the operands keep changing. The bench provokes the first with back-to-back valid inputs whose carries cross the half boundaries of the nodes. It provokes the second with idle gaps in which the operands are scrambled. A scoreboard queue judges every valid output. In every idle cycle, the output is compared with the last result presented.

// File: rtl/fxat_pkg.sv
package fxat_pkg;
  function automatic int unsigned lvl_count(input int unsigned n);
    return $clog2(n);
  endfunction
endpackage

// File: rtl/fxat_csel_add.sv
module fxat_csel_add #(
  parameter int unsigned WD = 5
) (
  input  logic [WD-1:0] a_i,
  input  logic [WD-1:0] b_i,
  input  logic          cin_i,
  output logic [WD:0]   sum_o
);
  localparam int unsigned LO = WD / 2;
  localparam int unsigned HI = WD - LO;

  logic [LO:0] lo_sum;
  logic [HI:0] hi_c0, hi_c1;

  assign lo_sum = {1'b0, a_i[LO-1:0]} + {1'b0, b_i[LO-1:0]} + {{LO{1'b0}}, cin_i};
  assign hi_c0  = {1'b0, a_i[WD-1:LO]} + {1'b0, b_i[WD-1:LO]};
  assign hi_c1  = {1'b0, a_i[WD-1:LO]} + {1'b0, b_i[WD-1:LO]} + {{HI{1'b0}}, 1'b1};

  // low-half carry picks the precomputed upper half
  assign sum_o = lo_sum[LO] ? {hi_c1, lo_sum[LO-1:0]} : {hi_c0, lo_sum[LO-1:0]};

  always_comb begin
    p_node_exact_r8: assert (sum_o == ({1'b0, a_i} + {1'b0, b_i} + {{WD{1'b0}}, cin_i}));
  end
endmodule

// File: rtl/fxat_tree.sv
module fxat_tree #(
  parameter int unsigned N_OPS = 8,
  parameter int unsigned KW    = 5
) (
  input  logic [N_OPS*KW-1:0]                          leaves_i,
  output logic [KW+fxat_pkg::lvl_count(N_OPS)-1:0]     total_o
);
  localparam int unsigned LV = fxat_pkg::lvl_count(N_OPS);

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int unsigned CNT = N_OPS >> (l + 1);
    localparam int unsigned IW  = KW + l;
    logic [IW:0] s [CNT];
    for (genvar j = 0; j < CNT; j++) begin : g_node
      logic [IW-1:0] a, b;
      if (l == 0) begin : g_leaf
        assign a = leaves_i[(2*j)*KW +: KW];
        assign b = leaves_i[(2*j+1)*KW +: KW];
      end else begin : g_inner
        assign a = g_lvl[l-1].s[2*j];
        assign b = g_lvl[l-1].s[2*j+1];
      end
      // first-level carry-ins of 1 supply the N/2 bias
      fxat_csel_add #(.WD(IW)) u_add (
        .a_i   (a),
        .b_i   (b),
        .cin_i ((l == 0) ? 1'b1 : 1'b0),
        .sum_o (s[j])
      );
    end
  end

  assign total_o = g_lvl[LV-1].s[0];
endmodule

// File: rtl/fxat_trunc_sum.sv
module fxat_trunc_sum #(
  parameter int unsigned N_OPS   = 8,
  parameter int unsigned OP_W    = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_OPS*OP_W-1:0]   in_ops_i,
  input  logic                    in_valid_i,
  output logic [OP_W-1:0]         out_sum_o,
  output logic                    out_valid_o
);
  localparam int unsigned P  = fxat_pkg::lvl_count(N_OPS);
  localparam int unsigned KW = OP_W - P;

  logic [N_OPS*KW-1:0] kept;
  logic [OP_W-1:0]     tree_sum;

  for (genvar i = 0; i < N_OPS; i++) begin : g_keep
    assign kept[i*KW +: KW] = in_ops_i[i*OP_W+P +: KW];
  end

  fxat_tree #(.N_OPS(N_OPS), .KW(KW)) u_tree (
    .leaves_i (kept),
    .total_o  (tree_sum)
  );

  // behavioural model for assertions only
  logic [31:0] ref_wide;
  always_comb begin
    ref_wide = N_OPS / 2;
    for (int i = 0; i < N_OPS; i++)
      ref_wide = ref_wide + 32'(in_ops_i[i*OP_W +: OP_W] >> P);
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_valid_o <= 1'b0;
        out_sum_o   <= '0;
      end else begin
        out_valid_o <= in_valid_i;
        if (in_valid_i) out_sum_o <= tree_sum;
      end
    end

    p_valid_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> out_valid_o);
    p_no_spurious_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> !out_valid_o);
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> $stable(out_sum_o));
    p_sum_ref_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> (32'(out_sum_o) == $past(ref_wide)));
  end else begin : g_comb
    assign out_sum_o   = tree_sum;
    assign out_valid_o = in_valid_i;
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (ref_wide < (32'd1 << OP_W)));
endmodule

// File: tb/test_fxat_trunc_sum.sv
module test_fxat_trunc_sum;
  localparam int unsigned N  = 8;
  localparam int unsigned W  = 8;
  localparam int unsigned P  = $clog2(N);
  localparam int unsigned NW = N * W;

  typedef struct {
    int unsigned exp;
    string       tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] ops = '0;
  logic          vld = 1'b0;
  logic [W-1:0]  sum;
  logic          sum_vld;

  item_t       sb[$];
  int          checks = 0;
  int          errors = 0;
  int          max_err = 0;
  int unsigned last_exp = 0;
  bit          have_last = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  fxat_trunc_sum #(.N_OPS(N), .OP_W(W), .REG_OUT(1'b1)) i_fxat_trunc_sum (
    .clk_i(clk), .rst_ni(rst_n), .in_ops_i(ops), .in_valid_i(vld),
    .out_sum_o(sum), .out_valid_o(sum_vld)
  );

  task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [NW-1:0] v, input string tag);
    item_t it;
    int unsigned s = N / 2;
    int unsigned full = 0;
    int e;
    for (int i = 0; i < N; i++) begin
      s    += int'(v[i*W +: W] >> P);
      full += int'(v[i*W +: W]);
    end
    e = int'(s) - int'(full >> P);
    if (e < 0) e = -e;
    if (e > max_err) max_err = e;
    it.exp = s % (1 << W);
    it.tag = tag;
    ops = v;
    vld = 1'b1;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int cyc);
    for (int c = 0; c < cyc; c++) begin
      vld = 1'b0;
      ops = {$urandom, $urandom};   // scrambled, must not reach output (R6)
      @(negedge clk);
    end
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && !done) begin
        if (sum_vld) begin
          if (sb.size() == 0) chk(1'b0, "R5 spurious valid", 1, 0);
          else begin
            it = sb.pop_front();
            chk(32'(sum) == it.exp, it.tag, sum, it.exp);
            last_exp  = it.exp;
            have_last = 1'b1;
          end
        end else if (have_last) begin
          chk(32'(sum) == last_exp, "R6 hold", sum, last_exp);
        end
      end
    end
  end

  initial begin
    logic [NW-1:0] base;
    repeat (3) @(negedge clk);
    chk(sum_vld == 1'b0, "R7 reset valid", sum_vld, 0);
    chk(sum == '0, "R7 reset sum", sum, 0);
    rst_n = 1'b1;
    @(negedge clk);

    drive('0, "R4 zeros");
    drive('1, "R3 all ones");
    idle(2);
    // R2: kept parts equal, low columns differ
    base = '0;
    for (int i = 0; i < N; i++) base[i*W +: W] = W'(8'(i * 40 + 9));
    drive(base, "R1 ramp");
    for (int i = 0; i < N; i++) base[i*W +: P] = '1;
    drive(base, "R2 low cols set");
    for (int i = 0; i < N; i++) base[i*W +: P] = P'(i);
    drive(base, "R2 low cols mixed");
    idle(3);
    // R8: carries crossing node half boundaries
    for (int i = 0; i < N; i++) base[i*W +: W] = (i % 2 == 0) ? W'(8'h18) : W'(8'h08);
    drive(base, "R8 half carry");
    for (int i = 0; i < N; i++) base[i*W +: W] = (i < N/2) ? W'(8'hF8) : W'(8'h08);
    drive(base, "R8 ripple through");
    idle(1);
    for (int k = 0; k < 40; k++) begin
      drive({$urandom, $urandom}, "R1 random");
      if (k % 7 == 3) idle(1);
    end
    idle(2);
    chk(sb.size() == 0, "R5 drained", sb.size(), 0);
    chk(max_err <= N / 2, "R9 error bound", max_err, N / 2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule